// File: doc/BRIEF.md
# Two-Byte Root Next-State Lookup

This block finds the next state of a multi-pattern string matcher when the scan sits at the root of its pattern trie. It may consume up to two text bytes in one lookup. A controller presents two bytes and a mode bit and pulses `start`. The block answers with the resolved state and the number of bytes the scan should advance, flagged by a one-cycle `done`.

There are two lookup modes. In indexed mode, each byte goes through a per-position code table (level 0 for the first byte, level 1 for the second). Each table returns a small sequential code. Code 0 means that no pattern has that character at that position. The two codes, concatenated, address a compact next-state table, and the answer arrives two cycles after `start`. In direct mode, the low bits of the two raw bytes address the same next-state table, and the answer arrives one cycle after `start`. Direct mode suits large pattern sets where the root has many successors. All three tables are loaded through a single write port. Computing their contents is the job of software.

Top module: `root_index_lookup`

## Requirements
- R1: After reset, `done` is 0, `next_state` is the root state (0) and `consumed` is 0.
- R2: Direct mode (`direct_mode`=1): the table address is {byte0[DIR_BITS-1:0], byte1[DIR_BITS-1:0]}, with byte0 in the upper field. `done` rises in the cycle after the `start` edge.
- R3: Indexed mode (`direct_mode`=0): byte0 reads the level-0 code table and byte1 reads the level-1 code table. The address is {code0, code1}, zero-extended, with code0 in the upper CODE_W bits. `done` is 0 in the cycle after `start` and 1 in the cycle after that.
- R4: A level-1 code of 0 gives the address {code0, 0}, so a one-byte (shorter) match entry is selected.
- R5: A next-state entry is {count[1:0], state[STATE_W-1:0]}. When `done` is 1, the state field appears on `next_state` and the count field appears on `consumed`.
- R6: An entry whose count field is 0 is empty. It yields `next_state` = root (0) and `consumed` = 1.
- R7: A `start` that arrives while an indexed lookup is in its second cycle is ignored. It causes no extra `done` and does not change the outputs.
- R8: `done` lasts one cycle per accepted lookup. `next_state` and `consumed` hold their values until the next `done`.
- R9: Write port: `wr_sel`=0 writes the level-0 code table and `wr_sel`=1 writes the level-1 code table, both using wr_addr[7:0] and wr_data[CODE_W-1:0]. `wr_sel`=2 writes the next-state table, using wr_addr[NT_AW-1:0] and all of wr_data. `wr_sel`=3 writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a lookup |
| direct_mode | input | 1 | 1 selects direct mode, 0 selects indexed mode |
| byte0 | input | 8 | First text byte |
| byte1 | input | 8 | Second text byte |
| wr_en | input | 1 | Table write strobe |
| wr_sel | input | 2 | Table select for a write |
| wr_addr | input | WR_AW (10) | Write address |
| wr_data | input | STATE_W+2 (10) | Write data |
| next_state | output | STATE_W (8) | Resolved next state |
| consumed | output | 2 | Bytes consumed by this lookup |
| done | output | 1 | Result valid pulse |

## Verification
The hardest situation to reach from the ports is a new `start` that lands exactly in the second cycle of an indexed lookup. In that cycle the pending read of the next-state table must win, and the new request must vanish without trace. The bench reaches it by holding `start` high for two consecutive cycles. On the second cycle it switches to direct mode with bytes whose direct entry differs from the indexed result. It then checks for a single `done` carrying the indexed answer, followed by unchanged outputs. The shorter-match case is reached by choosing a second byte that is absent from the level-1 code table.

// File: rtl/root_index_lookup.sv
module root_index_lookup #(
  parameter int STATE_W    = 8,
  parameter int CODE_W     = 3,
  parameter int DIR_BITS   = 5,
  parameter int ROOT_STATE = 0,
  localparam int NT_AW     = (2*DIR_BITS > 2*CODE_W) ? 2*DIR_BITS : 2*CODE_W,
  localparam int WR_AW     = (NT_AW > 8) ? NT_AW : 8,
  localparam int ENT_W     = STATE_W + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               direct_mode,
  input  logic [7:0]         byte0,
  input  logic [7:0]         byte1,
  input  logic               wr_en,
  input  logic [1:0]         wr_sel,
  input  logic [WR_AW-1:0]   wr_addr,
  input  logic [ENT_W-1:0]   wr_data,
  output logic [STATE_W-1:0] next_state,
  output logic [1:0]         consumed,
  output logic               done
);
  localparam int NT_DEPTH = 1 << NT_AW;

  logic [CODE_W-1:0] lvl0_tab [256];
  logic [CODE_W-1:0] lvl1_tab [256];
  logic [ENT_W-1:0]  nxt_tab  [NT_DEPTH];

  logic              pend;
  logic [CODE_W-1:0] code0_q, code1_q;
  logic [NT_AW-1:0]  rd_addr;
  logic [ENT_W-1:0]  ent;
  logic              empty;

  always_ff @(posedge clk) begin
    if (wr_en) begin
      case (wr_sel)
        2'd0: lvl0_tab[wr_addr[7:0]] <= wr_data[CODE_W-1:0];
        2'd1: lvl1_tab[wr_addr[7:0]] <= wr_data[CODE_W-1:0];
        2'd2: nxt_tab[wr_addr[NT_AW-1:0]] <= wr_data;
        default: ;
      endcase
    end
  end

  assign rd_addr = pend ? NT_AW'({code0_q, code1_q})
                        : NT_AW'({byte0[DIR_BITS-1:0], byte1[DIR_BITS-1:0]});
  assign ent   = nxt_tab[rd_addr];
  assign empty = (ent[ENT_W-1 -: 2] == 2'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend       <= 1'b0;
      code0_q    <= '0;
      code1_q    <= '0;
      done       <= 1'b0;
      next_state <= STATE_W'(ROOT_STATE);
      consumed   <= 2'd0;
    end else begin
      done <= 1'b0;
      pend <= 1'b0;
      if (pend || (start && direct_mode)) begin
        done       <= 1'b1;
        next_state <= empty ? STATE_W'(ROOT_STATE) : ent[STATE_W-1:0];
        consumed   <= empty ? 2'd1 : ent[ENT_W-1 -: 2];
      end else if (start) begin
        pend    <= 1'b1;
        code0_q <= lvl0_tab[byte0];
        code1_q <= lvl1_tab[byte1];
      end
    end
  end

  AST_DIRECT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (start && direct_mode && !pend) |=> done);                       // R2
  AST_INDEXED_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !direct_mode && !pend) |=> (!done && pend));           // R3
  AST_INDEXED_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    pend |=> done);                                                  // R3
  AST_BUSY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    pend |=> !pend);                                                 // R7
  AST_PROGRESS: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (consumed != 2'd0));                                    // R6
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(next_state) && $stable(consumed)));           // R8
endmodule

// File: tb/root_index_lookup_test.sv
module root_index_lookup_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 11;
  // {direct_mode, byte0, byte1, exp_state, exp_count}
  localparam logic [26:0] VEC [NV] = '{
    {1'b0, 8'h54, 8'h45, 8'd2,    2'd2},  // R3 T,E
    {1'b0, 8'h54, 8'h48, 8'd5,    2'd2},  // R3 T,H
    {1'b0, 8'h48, 8'h45, 8'd7,    2'd2},  // R3 H,E
    {1'b0, 8'h54, 8'h53, 8'd1,    2'd1},  // R4 T,S (S code 0)
    {1'b0, 8'h48, 8'h58, 8'd6,    2'd1},  // R4 H,X
    {1'b0, 8'h54, 8'h54, 8'd1,    2'd1},  // R3 T,T
    {1'b0, 8'h47, 8'h44, 8'd0,    2'd1},  // R6 G,D empty
    {1'b1, 8'h41, 8'h42, 8'd9,    2'd2},  // R2 A,B
    {1'b1, 8'h58, 8'h59, 8'h33,   2'd1},  // R2 X,Y
    {1'b1, 8'h51, 8'h52, 8'd0,    2'd1},  // R6 Q,R empty
    {1'b1, 8'h61, 8'h42, 8'd9,    2'd2}   // R2 low bits only
  };

  logic clk = 0, rst_n = 0, start = 0, direct_mode = 0, wr_en = 0;
  logic [7:0] byte0 = 0, byte1 = 0;
  logic [1:0] wr_sel = 0;
  logic [9:0] wr_addr = 0, wr_data = 0;
  logic [7:0] next_state;
  logic [1:0] consumed;
  logic done;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  root_index_lookup uut (.clk(clk), .rst_n(rst_n), .start(start),
    .direct_mode(direct_mode), .byte0(byte0), .byte1(byte1), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_addr(wr_addr), .wr_data(wr_data),
    .next_state(next_state), .consumed(consumed), .done(done));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input int a, input int d);
    @(negedge clk);
    wr_en = 1; wr_sel = sel; wr_addr = 10'(a); wr_data = 10'(d);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic lookup(input logic m, input logic [7:0] b0, input logic [7:0] b1,
                        input int es, input int ec, input string req);
    @(negedge clk);
    start = 1; direct_mode = m; byte0 = b0; byte1 = b1;
    @(negedge clk);
    start = 0;
    if (!m) begin
      chk({req, " gap"}, done, 0);
      @(negedge clk);
    end
    chk({req, " done"}, done, 1);
    chk({req, " state"}, next_state, es);
    chk({req, " count"}, consumed, ec);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 done", done, 0);
    chk("R1 state", next_state, 0);
    chk("R1 count", consumed, 0);
    rst_n = 1;
    for (int i = 0; i < 256; i++) begin wr(2'd0, i, 0); wr(2'd1, i, 0); end
    for (int i = 0; i < 1024; i++) wr(2'd2, i, 0);
    // R9 code tables: level0 H=1 T=2; level1 E=1 H=2 T=3
    wr(2'd0, 8'h48, 1); wr(2'd0, 8'h54, 2);
    wr(2'd1, 8'h45, 1); wr(2'd1, 8'h48, 2); wr(2'd1, 8'h54, 3);
    // R5 entries {count, state}
    wr(2'd2, 17, {2'd2, 8'd2});  wr(2'd2, 18, {2'd2, 8'd5});
    wr(2'd2, 9,  {2'd2, 8'd7});  wr(2'd2, 16, {2'd1, 8'd1});
    wr(2'd2, 8,  {2'd1, 8'd6});  wr(2'd2, 19, {2'd1, 8'd1});
    wr(2'd2, 34, {2'd2, 8'd9});  wr(2'd2, 793, {2'd1, 8'h33});
    wr(2'd2, 562, {2'd0, 8'h7F});  // R6 empty despite state bits
    for (int i = 0; i < NV; i++)
      lookup(VEC[i][26], VEC[i][25:18], VEC[i][17:10], int'(VEC[i][9:2]),
             int'(VEC[i][1:0]), "R2/R3/R4/R5/R6 vector");
    // R8 hold after done
    repeat (3) @(negedge clk);
    chk("R8 done low", done, 0);
    chk("R8 state held", next_state, 9);
    chk("R8 count held", consumed, 2);
    // R7 start during indexed second cycle
    @(negedge clk);
    start = 1; direct_mode = 0; byte0 = 8'h54; byte1 = 8'h48;
    @(negedge clk);
    direct_mode = 1; byte0 = 8'h58; byte1 = 8'h59;
    @(negedge clk);
    start = 0;
    chk("R7 done", done, 1);
    chk("R7 state", next_state, 5);
    @(negedge clk);
    chk("R7 no extra done", done, 0);
    chk("R7 state unchanged", next_state, 5);
    chk("R7 count unchanged", consumed, 2);
    // R9 wr_sel 3 writes nothing
    wr(2'd3, 17, {2'd1, 8'd99});
    wr(2'd3, 8'h54, 0);
    lookup(1'b0, 8'h54, 8'h45, 2, 2, "R9 sel3 ignored");
    // R9 overwrite through wr_sel 2
    wr(2'd2, 17, {2'd2, 8'd44});
    lookup(1'b0, 8'h54, 8'h45, 44, 2, "R9 rewrite");
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule